// File: doc/BRIEF.md
# Segment Selector Descriptor Fetch Unit

When a segment register is written in protected mode, the written 16-bit value is a selector. This block accepts that selector together with the number of the target segment register. It chooses the global or the local descriptor table, checks that the whole 8-byte entry lies inside the chosen table, and reads the descriptor as four 16-bit words through a read port that takes one read at a time. It decodes base, limit and access rights and keeps them in a small per-register cache. A global-table selector with index zero is the null selector: it never reaches memory and only marks the target cache entry invalid.

The same engine loads the on-chip local table register. A request flagged as a local-table load must name an entry in the global table. The base and limit of the descriptor found there become the local table's base and limit. Any problem (an entry outside the table limit, a local lookup while the local table is not loaded, a local-table load pointing into the local table, or a descriptor whose present bit is clear) raises the single `fault` output during the completion cycle. In that case no cached state changes. Privilege levels are carried in the selector but not checked.

Requests enter on a valid/ready pair. `req_ready` is high only while the engine is idle. A request is taken on a clock edge where both `req_valid` and `req_ready` are high, and the request fields are sampled at that edge only. The memory read port is also valid/ready: `rd_valid` stays high with a steady `rd_addr` until `rd_ready` accepts the read. The data comes back on `rsp_valid` on a later cycle and cannot be held off.

Top module: `seg_desc_fetch`

## Requirements
- R1: `req_ready` is high exactly when the engine is idle. After a request is taken, `req_ready` stays low until the cycle after `done`, so only one request is in progress at a time.
- R2: Selector bit 2 picks the table: 0 uses the global table's base and limit, 1 uses the local table register's base and limit. Bits 1:0 are ignored.
- R3: The four reads of a lookup go to table base + (selector with bits 2:0 cleared) + 0, 2, 4 and 6, in that order. A read is issued only after the previous response has arrived.
- R4: An entry is within bounds only when offset + 7 <= table limit. Otherwise the request faults without any memory read.
- R5: A global-table selector with bits 15:3 all zero issues no read and raises no fault. For a segment request it clears the target entry's valid flag. For a local-table load it clears the local table's valid flag.
- R6: A local-table selector with index 0 is looked up like any other local entry.
- R7: A local-table lookup while the local table register is not valid faults without any memory read.
- R8: Descriptor decoding: word 0 is the limit, word 1 is base bits 15:0, the low byte of word 2 is base bits 23:16, and the high byte of word 2 is the access-rights byte. In the 32-bit variant, the high byte of word 3 is base bits 31:24.
- R9: An access-rights byte with bit 7 (present) clear gives a fault and leaves the cache and the local table register unchanged.
- R10: A successful segment request writes valid, base, limit and access rights into the target entry only. The change is visible on the lookup port from the cycle after `done`.
- R11: A local-table load whose selector has bit 2 set faults without reading. A successful one sets the local table register valid with the fetched base and limit.
- R12: `done` is a single-cycle pulse closing every accepted request, and `fault` is high only together with `done`.
- R13: While `rd_valid` is high and `rd_ready` low, `rd_valid` and `rd_addr` hold on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_ltab | input | 1 | 1: load the local table register, 0: load a segment register |
| req_seg | input | SEG_W | Target segment register number |
| req_sel | input | 16 | Selector value |
| gtab_base | input | AW | Global table linear base (24 or 32 bits) |
| gtab_limit | input | 16 | Global table limit in bytes |
| rd_valid | output | 1 | Memory read request |
| rd_ready | input | 1 | Memory accepts the read |
| rd_addr | output | AW | Byte address of the 16-bit word to read |
| rsp_valid | input | 1 | Read data present |
| rsp_data | input | 16 | Read data |
| done | output | 1 | Request complete (one cycle) |
| fault | output | 1 | Request failed, meaningful with done |
| ltab_valid | output | 1 | Local table register holds a table |
| ltab_base | output | AW | Local table base |
| ltab_limit | output | 16 | Local table limit |
| look_seg | input | SEG_W | Cache entry to observe |
| look_valid | output | 1 | Entry holds a descriptor |
| look_base | output | AW | Entry base |
| look_limit | output | 16 | Entry limit |
| look_ar | output | 8 | Entry access-rights byte |

## Verification
The assertions assume that `rsp_valid` arrives only for a read that was accepted and is still outstanding, with at most one response per read. They also assume that `gtab_base` and `gtab_limit` do not change while a request is in progress. The bench's memory model returns each response exactly one cycle after acceptance and inserts `rd_ready` stalls on a fixed pattern. The bench changes the global table limit only between requests, while `req_ready` is high. It holds `req_valid` only until the handshake edge.

// File: rtl/sdf_pkg.sv
package sdf_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_F0,
    ST_F1,
    ST_F2,
    ST_F3,
    ST_DONE
  } sdf_state_e;

  localparam int SEL_W        = 16;
  localparam int WORD_W       = 16;
  localparam int ENTRY_BYTES  = 8;
  localparam int PRESENT_BIT  = 15;  // bit 7 of the rights byte, inside word 2

endpackage

// File: rtl/sdf_addr_gen.sv
module sdf_addr_gen #(
  parameter int AW = 24
) (
  input  logic [15:2]   sel_hi,
  input  logic          ltab_op,
  input  logic [AW-1:0] gtab_base,
  input  logic [15:0]   gtab_limit,
  input  logic          ltab_valid,
  input  logic [AW-1:0] ltab_base,
  input  logic [15:0]   ltab_limit,
  input  logic [1:0]    word_idx,
  output logic [AW-1:0] addr,
  output logic          is_null,
  output logic          reject
);
  logic          use_local;
  logic [15:0]   offset;
  logic [15:0]   tab_limit;
  logic [AW-1:0] tab_base;
  logic [16:0]   last_byte;
  logic          in_bounds;

  assign use_local = sel_hi[2];
  assign offset    = {sel_hi[15:3], 3'b000};
  assign tab_limit = use_local ? ltab_limit : gtab_limit;
  assign tab_base  = use_local ? ltab_base  : gtab_base;

  // the last byte of the 8-byte entry must not pass the limit
  assign last_byte = {1'b0, offset} + 17'd7;
  assign in_bounds = last_byte <= {1'b0, tab_limit};

  assign is_null = !use_local && (sel_hi[15:3] == 13'd0);
  assign reject  = (ltab_op && use_local) || (use_local && !ltab_valid) || !in_bounds;

  assign addr = tab_base + AW'(offset) + AW'({word_idx, 1'b0});
endmodule

// File: rtl/sdf_ctrl.sv
module sdf_ctrl
  import sdf_pkg::*;
#(
  parameter int AW    = 24,
  parameter int SEG_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_ltab,
  input  logic [SEG_W-1:0] req_seg,
  input  logic [15:2]      req_sel_hi,
  output logic [15:2]      sel_hi,
  output logic             ltab_op,
  output logic [SEG_W-1:0] seg,
  output logic [1:0]       word_idx,
  input  logic [AW-1:0]    addr_in,
  input  logic             is_null,
  input  logic             reject,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [AW-1:0]    rd_addr,
  input  logic             rsp_valid,
  input  logic [15:0]      rsp_data,
  output logic             done,
  output logic             fault,
  output logic             commit_seg,
  output logic             inval_seg,
  output logic             commit_ltab,
  output logic             inval_ltab,
  output logic [AW-1:0]    dec_base,
  output logic [15:0]      dec_limit,
  output logic [7:0]       dec_ar
);
  sdf_state_e       state_q, state_d;
  logic [15:2]      sel_q;
  logic             ltab_q;
  logic [SEG_W-1:0] seg_q;
  logic             issued_q, fault_q, null_q;
  logic [15:0]      w0_q, w1_q, w2_q;
  logic             in_fetch, capture, ok;

  assign in_fetch = (state_q == ST_F0) || (state_q == ST_F1) ||
                    (state_q == ST_F2) || (state_q == ST_F3);

  always_comb begin
    case (state_q)
      ST_F1:   word_idx = 2'd1;
      ST_F2:   word_idx = 2'd2;
      ST_F3:   word_idx = 2'd3;
      default: word_idx = 2'd0;
    endcase
  end

  assign req_ready = (state_q == ST_IDLE);
  assign rd_valid  = in_fetch && !issued_q;
  assign rd_addr   = addr_in;
  assign capture   = in_fetch && issued_q && rsp_valid;
  assign sel_hi    = sel_q;
  assign ltab_op   = ltab_q;
  assign seg       = seg_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (req_valid) state_d = ST_CHECK;
      ST_CHECK: state_d = (is_null || reject) ? ST_DONE : ST_F0;
      ST_F0:    if (capture) state_d = ST_F1;
      ST_F1:    if (capture) state_d = ST_F2;
      ST_F2:    if (capture) state_d = ST_F3;
      ST_F3:    if (capture) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      sel_q    <= '0;
      ltab_q   <= 1'b0;
      seg_q    <= '0;
      issued_q <= 1'b0;
      fault_q  <= 1'b0;
      null_q   <= 1'b0;
      w0_q     <= '0;
      w1_q     <= '0;
      w2_q     <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && req_valid) begin
        sel_q   <= req_sel_hi;
        ltab_q  <= req_ltab;
        seg_q   <= req_seg;
        fault_q <= 1'b0;
        null_q  <= 1'b0;
      end
      if (state_q == ST_CHECK) begin
        null_q  <= is_null;
        fault_q <= !is_null && reject;
      end
      if (rd_valid && rd_ready) issued_q <= 1'b1;
      else if (capture)         issued_q <= 1'b0;
      if (capture) begin
        case (word_idx)
          2'd0:    w0_q <= rsp_data;
          2'd1:    w1_q <= rsp_data;
          2'd2:    w2_q <= rsp_data;
          default: ;
        endcase
      end
    end
  end

  generate
    if (AW == 32) begin : g_wide
      logic [7:0] w3_hi_q;
      always_ff @(posedge clk) begin
        if (!rst_n)                          w3_hi_q <= '0;
        else if (capture && word_idx == 2'd3) w3_hi_q <= rsp_data[15:8];
      end
      assign dec_base = {w3_hi_q, w2_q[7:0], w1_q};
    end else begin : g_narrow
      assign dec_base = AW'({w2_q[7:0], w1_q});
    end
  endgenerate

  assign dec_limit = w0_q;
  assign dec_ar    = w2_q[15:8];

  assign done        = (state_q == ST_DONE);
  assign fault       = done && (fault_q || (!null_q && !w2_q[PRESENT_BIT]));
  assign ok          = done && !fault && !null_q;
  assign commit_seg  = ok && !ltab_q;
  assign commit_ltab = ok && ltab_q;
  assign inval_seg   = done && null_q && !ltab_q;
  assign inval_ltab  = done && null_q && ltab_q;

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr))); // R13
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R12
  AST_FAULT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> done); // R12
  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R1
  AST_NULL_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CHECK && is_null) |=> (!rd_valid && done && !fault)); // R5
  AST_REJECT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CHECK && reject && !is_null) |=> (!rd_valid && fault)); // R4
endmodule

// File: rtl/sdf_seg_cache.sv
module sdf_seg_cache #(
  parameter int AW      = 24,
  parameter int NUM_SEG = 4,
  parameter int SEG_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_inval,
  input  logic [SEG_W-1:0] wr_idx,
  input  logic [AW-1:0]    wr_base,
  input  logic [15:0]      wr_limit,
  input  logic [7:0]       wr_ar,
  input  logic [SEG_W-1:0] look_idx,
  output logic             look_valid,
  output logic [AW-1:0]    look_base,
  output logic [15:0]      look_limit,
  output logic [7:0]       look_ar
);
  logic          ent_v [NUM_SEG];
  logic [AW-1:0] ent_b [NUM_SEG];
  logic [15:0]   ent_l [NUM_SEG];
  logic [7:0]    ent_a [NUM_SEG];

  generate
    for (genvar i = 0; i < NUM_SEG; i++) begin : g_ent
      logic          v_q;
      logic [AW-1:0] b_q;
      logic [15:0]   l_q;
      logic [7:0]    a_q;
      logic          hit;
      assign hit = (wr_idx == SEG_W'(i));
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          v_q <= 1'b0;
          b_q <= '0;
          l_q <= '0;
          a_q <= '0;
        end else if (hit && wr_en) begin
          v_q <= 1'b1;
          b_q <= wr_base;
          l_q <= wr_limit;
          a_q <= wr_ar;
        end else if (hit && wr_inval) begin
          v_q <= 1'b0;
        end
      end
      assign ent_v[i] = v_q;
      assign ent_b[i] = b_q;
      assign ent_l[i] = l_q;
      assign ent_a[i] = a_q;
    end
  endgenerate

  always_comb begin
    look_valid = 1'b0;
    look_base  = '0;
    look_limit = '0;
    look_ar    = '0;
    for (int i = 0; i < NUM_SEG; i++) begin
      if (look_idx == SEG_W'(i)) begin
        look_valid = ent_v[i];
        look_base  = ent_b[i];
        look_limit = ent_l[i];
        look_ar    = ent_a[i];
      end
    end
  end

  AST_WRITE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_en, wr_inval})); // R10
  AST_WRITE_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && look_idx == wr_idx) |=> (look_idx != $past(wr_idx) || look_valid)); // R10
endmodule

// File: rtl/seg_desc_fetch.sv
module seg_desc_fetch #(
  parameter  int WIDE_BASE = 0,
  parameter  int NUM_SEG   = 4,
  localparam int AW        = (WIDE_BASE != 0) ? 32 : 24,
  localparam int SEG_W     = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_ltab,
  input  logic [SEG_W-1:0] req_seg,
  input  logic [15:0]      req_sel,
  input  logic [AW-1:0]    gtab_base,
  input  logic [15:0]      gtab_limit,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [AW-1:0]    rd_addr,
  input  logic             rsp_valid,
  input  logic [15:0]      rsp_data,
  output logic             done,
  output logic             fault,
  output logic             ltab_valid,
  output logic [AW-1:0]    ltab_base,
  output logic [15:0]      ltab_limit,
  input  logic [SEG_W-1:0] look_seg,
  output logic             look_valid,
  output logic [AW-1:0]    look_base,
  output logic [15:0]      look_limit,
  output logic [7:0]       look_ar
);
  logic [15:2]      sel_hi;
  logic             ltab_op;
  logic [SEG_W-1:0] seg;
  logic [1:0]       word_idx;
  logic [AW-1:0]    fetch_addr;
  logic             is_null, reject;
  logic             commit_seg, inval_seg, commit_ltab, inval_ltab;
  logic [AW-1:0]    dec_base;
  logic [15:0]      dec_limit;
  logic [7:0]       dec_ar;
  logic             unused_rpl;

  assign unused_rpl = &{1'b0, req_sel[1:0]};

  sdf_addr_gen #(.AW(AW)) u_addr (
    .sel_hi     (sel_hi),
    .ltab_op    (ltab_op),
    .gtab_base  (gtab_base),
    .gtab_limit (gtab_limit),
    .ltab_valid (ltab_valid),
    .ltab_base  (ltab_base),
    .ltab_limit (ltab_limit),
    .word_idx   (word_idx),
    .addr       (fetch_addr),
    .is_null    (is_null),
    .reject     (reject)
  );

  sdf_ctrl #(.AW(AW), .SEG_W(SEG_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_ltab    (req_ltab),
    .req_seg     (req_seg),
    .req_sel_hi  (req_sel[15:2]),
    .sel_hi      (sel_hi),
    .ltab_op     (ltab_op),
    .seg         (seg),
    .word_idx    (word_idx),
    .addr_in     (fetch_addr),
    .is_null     (is_null),
    .reject      (reject),
    .rd_valid    (rd_valid),
    .rd_ready    (rd_ready),
    .rd_addr     (rd_addr),
    .rsp_valid   (rsp_valid),
    .rsp_data    (rsp_data),
    .done        (done),
    .fault       (fault),
    .commit_seg  (commit_seg),
    .inval_seg   (inval_seg),
    .commit_ltab (commit_ltab),
    .inval_ltab  (inval_ltab),
    .dec_base    (dec_base),
    .dec_limit   (dec_limit),
    .dec_ar      (dec_ar)
  );

  sdf_seg_cache #(.AW(AW), .NUM_SEG(NUM_SEG), .SEG_W(SEG_W)) u_cache (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (commit_seg),
    .wr_inval   (inval_seg),
    .wr_idx     (seg),
    .wr_base    (dec_base),
    .wr_limit   (dec_limit),
    .wr_ar      (dec_ar),
    .look_idx   (look_seg),
    .look_valid (look_valid),
    .look_base  (look_base),
    .look_limit (look_limit),
    .look_ar    (look_ar)
  );

  // local table register, filled through a global-table lookup
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ltab_valid <= 1'b0;
      ltab_base  <= '0;
      ltab_limit <= '0;
    end else if (commit_ltab) begin
      ltab_valid <= 1'b1;
      ltab_base  <= dec_base;
      ltab_limit <= dec_limit;
    end else if (inval_ltab) begin
      ltab_valid <= 1'b0;
    end
  end

  AST_LTAB_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ltab |=> ltab_valid); // R11
  AST_LTAB_HOLD_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> ($stable(ltab_valid) && $stable(ltab_base) && $stable(ltab_limit))); // R9
endmodule

// File: tb/seg_desc_fetch_tb.sv
module seg_desc_fetch_tb;
  localparam int AW = 24;
  localparam int NS = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_ltab = 1'b0;
  logic [1:0]    req_seg = '0;
  logic [15:0]   req_sel = '0;
  logic [AW-1:0] gtab_base = 24'h000100;
  logic [15:0]   gtab_limit = 16'h003F;
  logic          rd_valid;
  logic          rd_ready = 1'b0;
  logic [AW-1:0] rd_addr;
  logic          rsp_valid = 1'b0;
  logic [15:0]   rsp_data = '0;
  logic          done, fault;
  logic          ltab_valid;
  logic [AW-1:0] ltab_base;
  logic [15:0]   ltab_limit;
  logic [1:0]    look_seg = '0;
  logic          look_valid;
  logic [AW-1:0] look_base;
  logic [15:0]   look_limit;
  logic [7:0]    look_ar;

  seg_desc_fetch #(.WIDE_BASE(0), .NUM_SEG(NS)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_ltab(req_ltab), .req_seg(req_seg), .req_sel(req_sel),
    .gtab_base(gtab_base), .gtab_limit(gtab_limit),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .done(done), .fault(fault),
    .ltab_valid(ltab_valid), .ltab_base(ltab_base), .ltab_limit(ltab_limit),
    .look_seg(look_seg), .look_valid(look_valid), .look_base(look_base),
    .look_limit(look_limit), .look_ar(look_ar)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int done_cnt = 0;
  bit finished = 0;

  logic [7:0] mem [0:4095];

  // reference state
  bit            m_v [NS];
  logic [AW-1:0] m_b [NS];
  logic [15:0]   m_l [NS];
  logic [7:0]    m_a [NS];
  bit            m_lv = 0;
  logic [AW-1:0] m_lb = '0;
  logic [15:0]   m_ll = '0;
  bit            busy = 0;

  // expectation for the request in flight
  string         cur_tag = "";
  bit            e_fault, e_null, e_ltab;
  int            e_reads, e_seg;
  logic [AW-1:0] e_addr0, e_base;
  logic [15:0]   e_lim;
  logic [7:0]    e_ar;
  int            reads = 0;

  bit            rsp_sched = 0;
  logic [15:0]   rsp_word = '0;
  bit            hold_prev = 0;
  logic [AW-1:0] addr_prev = '0;
  bit            done_prev = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] memw(input int a);
    return {mem[(a + 1) & 4095], mem[a & 4095]};
  endfunction

  task automatic put_desc(input int a, input logic [15:0] lim,
                          input logic [23:0] base, input logic [7:0] ar);
    mem[a]   = lim[7:0];
    mem[a+1] = lim[15:8];
    mem[a+2] = base[7:0];
    mem[a+3] = base[15:8];
    mem[a+4] = base[23:16];
    mem[a+5] = ar;
    mem[a+6] = 8'h00;
    mem[a+7] = 8'h00;
  endtask

  task automatic compute_exp();
    bit            loc;
    logic [15:0]   off, lim;
    logic [AW-1:0] base;
    int            a;
    loc     = req_sel[2];
    off     = {req_sel[15:3], 3'b000};
    lim     = loc ? m_ll : gtab_limit;
    base    = loc ? m_lb : gtab_base;
    e_ltab  = req_ltab;
    e_seg   = int'(req_seg);
    e_null  = 0;
    e_fault = 0;
    e_reads = 0;
    e_addr0 = base + AW'(off);
    if (!loc && req_sel[15:3] == 13'd0) e_null = 1;
    else if (req_ltab && loc) e_fault = 1;
    else if (loc && !m_lv) e_fault = 1;
    else if ({1'b0, off} + 17'd7 > {1'b0, lim}) e_fault = 1;
    else begin
      e_reads = 4;
      a       = int'(e_addr0);
      e_lim   = memw(a);
      e_base  = {memw(a + 4)[7:0], memw(a + 2)};
      e_ar    = memw(a + 4)[15:8];
      if (!e_ar[7]) e_fault = 1;
    end
  endtask

  // monitor, reference model and memory responder
  initial begin
    for (int i = 0; i < NS; i++) begin
      m_v[i] = 0; m_b[i] = '0; m_l[i] = '0; m_a[i] = '0;
    end
    forever begin
      @(negedge clk);
      #5;
      cyc++;
      if (rst_n && !finished) begin
        chk(req_ready == !busy, "R1", "req_ready", req_ready, !busy);
        chk(look_valid == m_v[look_seg], "R10", "look_valid", look_valid, m_v[look_seg]);
        if (m_v[look_seg]) begin
          chk(look_base == m_b[look_seg], "R8/R10", "look_base", look_base, m_b[look_seg]);
          chk(look_limit == m_l[look_seg], "R8/R10", "look_limit", look_limit, m_l[look_seg]);
          chk(look_ar == m_a[look_seg], "R8/R10", "look_ar", look_ar, m_a[look_seg]);
        end
        chk(ltab_valid == m_lv, "R11", "ltab_valid", ltab_valid, m_lv);
        if (m_lv) begin
          chk(ltab_base == m_lb, "R11", "ltab_base", ltab_base, m_lb);
          chk(ltab_limit == m_ll, "R11", "ltab_limit", ltab_limit, m_ll);
        end
        chk(!(fault && !done), "R12", "fault without done", fault, 0);
        chk(!(done && done_prev), "R12", "done longer than a cycle", done, 0);
        chk(!(done && !busy), "R12", "done while idle", done, 0);
        if (hold_prev)
          chk(rd_valid && rd_addr == addr_prev, "R13", "read not held", rd_addr, addr_prev);
        if (done && busy) begin
          chk(fault == e_fault, cur_tag, "fault", fault, e_fault);
          chk(reads == e_reads, cur_tag, "read count", reads, e_reads);
          if (!e_fault) begin
            if (e_null) begin
              if (e_ltab) m_lv = 0; else m_v[e_seg] = 0;
            end else if (e_ltab) begin
              m_lv = 1; m_lb = e_base; m_ll = e_lim;
            end else begin
              m_v[e_seg] = 1; m_b[e_seg] = e_base; m_l[e_seg] = e_lim; m_a[e_seg] = e_ar;
            end
          end
          busy = 0;
          done_cnt++;
        end
        done_prev = done;
        if (!busy && req_valid && req_ready) begin
          busy  = 1;
          reads = 0;
          compute_exp();
        end
        // memory side
        rsp_valid = rsp_sched;
        rsp_data  = rsp_sched ? rsp_word : 16'h0000;
        rsp_sched = 0;
        rd_ready  = (cyc % 3) != 1;
        if (rd_valid && rd_ready) begin
          chk(rd_addr == e_addr0 + AW'(2 * reads), "R3", "read address", rd_addr,
              e_addr0 + AW'(2 * reads));
          reads++;
          rsp_sched = 1;
          rsp_word  = memw(int'(rd_addr));
        end
        hold_prev = rd_valid && !rd_ready;
        addr_prev = rd_addr;
        look_seg  = look_seg + 2'd1;
      end
    end
  end

  task automatic do_req(input bit lt, input int sg, input logic [15:0] sel,
                        input string tag);
    int start;
    @(negedge clk);
    #1;
    cur_tag   = tag;
    start     = done_cnt;
    req_ltab  = lt;
    req_seg   = 2'(sg);
    req_sel   = sel;
    req_valid = 1'b1;
    forever begin
      if (req_ready) break;
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    while (done_cnt == start) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    // global table at 0x100
    put_desc(32'h108, 16'h0FFF, 24'h012345, 8'h92);
    put_desc(32'h110, 16'h00FF, 24'hABCDEF, 8'h12);  // not present
    put_desc(32'h118, 16'h0017, 24'h000800, 8'h82);  // local table
    put_desc(32'h120, 16'h1234, 24'h5A5A5A, 8'hF3);
    put_desc(32'h138, 16'h7777, 24'h777777, 8'h9A);
    put_desc(32'h140, 16'h4444, 24'h444444, 8'h92);  // beyond a 0x3F limit
    // local table at 0x800
    put_desc(32'h800, 16'h2222, 24'h0FEDCB, 8'h96);
    put_desc(32'h808, 16'h0001, 24'h100000, 8'h93);
    put_desc(32'h810, 16'h3333, 24'h222222, 8'h92);
    put_desc(32'h818, 16'h5555, 24'h333333, 8'h92);  // beyond 0x17 limit

    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1", "reset req_ready", req_ready, 1);
    chk(done == 1'b0 && fault == 1'b0, "R12", "reset done/fault", {done, fault}, 0);
    chk(rd_valid == 1'b0, "R13", "reset rd_valid", rd_valid, 0);
    chk(ltab_valid == 1'b0, "R11", "reset ltab_valid", ltab_valid, 0);
    #1 rst_n = 1'b1;

    do_req(0, 0, 16'h0008, "R2/R3/R8/R10 global load");
    do_req(0, 1, 16'h0010, "R9 not present");
    do_req(0, 2, 16'h000C, "R7 local without table");
    do_req(1, 0, 16'h001C, "R11 local-table load from local table");
    do_req(1, 0, 16'h0018, "R11 local-table load");
    do_req(0, 2, 16'h0004, "R6 local index 0");
    do_req(0, 3, 16'h000E, "R2 local index 1 rpl ignored");
    do_req(0, 1, 16'h001C, "R4 local over limit");
    do_req(0, 0, 16'h0003, "R5 global null");
    do_req(0, 1, 16'h0038, "R4 last entry fits limit");
    do_req(0, 2, 16'h0040, "R4 entry past limit");
    gtab_limit = 16'h003E;
    do_req(0, 0, 16'h0038, "R4 limit one byte short");
    do_req(0, 3, 16'h0021, "R2/R10 global load");
    do_req(1, 0, 16'h0000, "R5/R11 null local-table load");
    do_req(0, 2, 16'h0004, "R7 local after table cleared");

    repeat (4) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule